// File: doc/BRIEF.md
# Maskable Interrupt Status Unit with Read-to-Clear Registers

This unit collects twelve event sources into one interrupt line. Ten of the sources are sticky: a one-cycle pulse on the source sets a status bit, and the bit stays set until software clears it. The other two sources (receive full and transmit empty) are levels that follow a FIFO-threshold condition computed elsewhere. These two cannot be cleared. A mask register selects which status bits reach the interrupt output. The output is the OR of the raw status ANDed with the mask.

Software clears status with reads, not writes. Each sticky source has its own clear register, and reading that register returns the bit and clears it. A combined clear register drops every sticky bit in one read. A word that records the cause of a transmit abort is gathered beside the status bits. It is emptied by the same reads that clear the transmit-abort bit. Register access uses a simple port with an address, a read strobe, a write strobe and data.

Top module: `irq_rdclr_ctrl`

## Requirements
- R1: Sticky sources sit at these bit positions: 0 rx underflow, 1 rx overflow, 3 tx overflow, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop detected, 10 start detected, 11 general call. A one-cycle pulse on `src_in[i]` sets raw bit i at the next clock edge. The bit stays set until it is cleared. Raw status is read at byte offset 0x34 in bits [11:0], and resets to zero.
- R2: Bits 2 (rx full) and 4 (tx empty) are level sources. Their raw bit equals `src_in` in the same cycle, and no clear read changes them.
- R3: The masked status at offset 0x2C reads as raw AND mask.
- R4: `irq` is high exactly when raw AND mask is non-zero. It is combinational from the stored state and the level inputs.
- R5: The mask register at offset 0x30 is written from `wr_data[11:0]` and reads back the same value. Its reset value is 0x254, which enables rx full, tx empty, tx abort and stop detected.
- R6: Each sticky source has a clear register. The offsets start at 0x44 and step by 4 in ascending bit order, skipping bits 2 and 4: 0x44 bit0, 0x48 bit1, 0x4C bit3, 0x50 bit5, 0x54 bit6, 0x58 bit7, 0x5C bit8, 0x60 bit9, 0x64 bit10, 0x68 bit11. A read returns that bit's value before the clear in bit 0, and clears only that bit.
- R7: A read of offset 0x40 returns in bit 0 the OR of all sticky bits, then clears every sticky bit. It leaves the level bits and the mask unchanged.
- R8: When a source pulse arrives in the same cycle as a clear read of that source, the bit ends up set.
- R9: The abort word (16 bits, offset 0x80) ORs in `abrt_src_in` on every cycle with a tx-abort pulse (bit 6). It is emptied by a read of 0x54 or of 0x40, and no other read affects it. A capture in the same cycle as such a read leaves exactly the newly captured value.
- R10: Writes to any offset other than 0x30 change nothing. Reads of offsets that are not clear registers clear nothing.
- R11: Read data appears on `rd_data` at the clock edge that samples `rd_en`. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 12 | Event pulses (sticky bits) and levels (bits 2 and 4) |
| abrt_src_in | input | 16 | Abort cause captured with a tx-abort pulse |
| addr | input | 8 | Byte offset of the register access |
| rd_en | input | 1 | Read strobe; a read of a clear offset clears |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | OR of masked status |

## Verification
The bench sweeps every source bit one at a time. After each sweep it clears the sticky bits one by one and checks that the remaining raw pattern is exactly right. A clear decoder that was off by one slot around the skipped level bits would clear the wrong source. A decoder that ignored the read strobe would clear on writes. The bench also lands a source pulse in the same cycle as its clear read, and an abort capture in the same cycle as the abort clear. If clear won over set, the bench would see lost events. Mask and raw patterns are varied together so that masked status and `irq` are compared against an arithmetic model. The combined clear is checked to spare the level bits and the mask.

// File: rtl/irq_rdclr_pkg.sv
package irq_rdclr_pkg;

   localparam int unsigned OFF_MASKED  = 32'h2C;
   localparam int unsigned OFF_MASK    = 32'h30;
   localparam int unsigned OFF_RAW     = 32'h34;
   localparam int unsigned OFF_CLR_ALL = 32'h40;
   localparam int unsigned OFF_CLR_0   = 32'h44;
   localparam int unsigned OFF_ABRT    = 32'h80;

   // slot of a sticky bit among the clear registers: sticky bits below it
   function automatic int unsigned clr_slot(input int unsigned idx,
                                            input logic [31:0] lvl_msk);
      int unsigned n;
      n = 0;
      for (int unsigned k = 0; k < 32; k++) begin
         if (k < idx && !lvl_msk[k]) n++;
      end
      return n;
   endfunction

   function automatic int unsigned clr_off(input int unsigned idx,
                                           input logic [31:0] lvl_msk);
      return OFF_CLR_0 + 4 * clr_slot(idx, lvl_msk);
   endfunction

endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic stat_o
);
   logic q;

   // set wins: an event in the clearing cycle is kept
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (set_i) q <= 1'b1;
      else if (clr_i) q <= 1'b0;
   end

   assign stat_o = q;
endmodule

// File: rtl/irq_abort_word.sv
module irq_abort_word #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap_i,
   input  logic [W-1:0] src_i,
   input  logic         clr_i,
   output logic [W-1:0] word_o
);
   logic [W-1:0] q;
   logic [W-1:0] kept;
   logic [W-1:0] fresh;

   assign kept  = clr_i ? '0 : q;
   assign fresh = cap_i ? src_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= kept | fresh;
   end

   assign word_o = q;
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import irq_rdclr_pkg::*;
#(
   parameter int unsigned          NUM_SRC  = 12,
   parameter logic [NUM_SRC-1:0]   LVL_MSK  = 12'h014,
   parameter int unsigned          ADDR_W   = 8,
   parameter int unsigned          DATA_W   = 32,
   parameter int unsigned          ABRT_W   = 16,
   parameter logic [NUM_SRC-1:0]   MASK_RST = 12'h254
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               rd_en,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [NUM_SRC-1:0] raw_i,
   input  logic [ABRT_W-1:0]  abrt_i,
   output logic [NUM_SRC-1:0] mask_o,
   output logic [NUM_SRC-1:0] clr_hit_o,
   output logic               clr_all_o,
   output logic [DATA_W-1:0]  rd_data_o
);
   localparam logic [NUM_SRC-1:0] STICKY = ~LVL_MSK;

   logic [NUM_SRC-1:0] addr_hit;
   logic [NUM_SRC-1:0] mask_q;
   logic [DATA_W-1:0]  rd_next;
   logic [DATA_W-1:0]  rd_q;
   logic               at_mask, at_masked, at_raw, at_all, at_abrt;

   assign at_mask   = (addr == ADDR_W'(OFF_MASK));
   assign at_masked = (addr == ADDR_W'(OFF_MASKED));
   assign at_raw    = (addr == ADDR_W'(OFF_RAW));
   assign at_all    = (addr == ADDR_W'(OFF_CLR_ALL));
   assign at_abrt   = (addr == ADDR_W'(OFF_ABRT));

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_dec
      if (LVL_MSK[i]) begin : g_lvl
         assign addr_hit[i] = 1'b0;
      end else begin : g_stk
         localparam int unsigned OFF = clr_off(i, 32'(LVL_MSK));
         assign addr_hit[i] = (addr == ADDR_W'(OFF));
      end
   end

   assign clr_hit_o = addr_hit & {NUM_SRC{rd_en}};
   assign clr_all_o = rd_en & at_all;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 mask_q <= MASK_RST;
      else if (wr_en && at_mask)  mask_q <= wr_data[NUM_SRC-1:0];
   end

   always_comb begin
      rd_next = '0;
      if (at_masked)     rd_next[NUM_SRC-1:0] = raw_i & mask_q;
      else if (at_mask)  rd_next[NUM_SRC-1:0] = mask_q;
      else if (at_raw)   rd_next[NUM_SRC-1:0] = raw_i;
      else if (at_all)   rd_next[0] = |(raw_i & STICKY);
      else if (at_abrt)  rd_next[ABRT_W-1:0] = abrt_i;
      else if (|addr_hit) rd_next[0] = |(raw_i & addr_hit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= rd_next;
   end

   if (DATA_W > NUM_SRC) begin : g_unused
      logic unused_wr_hi;
      assign unused_wr_hi = ^wr_data[DATA_W-1:NUM_SRC];
   end

   assign mask_o    = mask_q;
   assign rd_data_o = rd_q;
endmodule

// File: rtl/irq_rdclr_ctrl.sv
module irq_rdclr_ctrl
   import irq_rdclr_pkg::*;
#(
   parameter int unsigned          NUM_SRC  = 12,
   parameter logic [NUM_SRC-1:0]   LVL_MSK  = 12'h014,
   parameter logic [NUM_SRC-1:0]   MASK_RST = 12'h254,
   parameter int unsigned          TXA_BIT  = 6,
   parameter int unsigned          ADDR_W   = 8,
   parameter int unsigned          DATA_W   = 32,
   parameter int unsigned          ABRT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic [ABRT_W-1:0]  abrt_src_in,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               rd_en,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   output logic               irq
);
   if (NUM_SRC > DATA_W || NUM_SRC > 32)   begin : g_chk_n  $error("NUM_SRC too wide");  end
   if (ABRT_W > DATA_W)                    begin : g_chk_a  $error("ABRT_W too wide");   end
   if (ADDR_W < 8)                         begin : g_chk_ad $error("ADDR_W below 8");    end
   if (TXA_BIT >= NUM_SRC)                 begin : g_chk_t  $error("TXA_BIT range");     end
   else if (LVL_MSK[TXA_BIT])              begin : g_chk_tl $error("TXA_BIT is level");  end

   logic [NUM_SRC-1:0] raw_stat;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] clr_hit;
   logic               clr_all;
   logic [ABRT_W-1:0]  abrt_q;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (LVL_MSK[i]) begin : g_lvl
         assign raw_stat[i] = src_in[i];
      end else begin : g_stk
         irq_evt_latch u_lat (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (src_in[i]),
            .clr_i  (clr_hit[i] | clr_all),
            .stat_o (raw_stat[i])
         );
      end
   end

   irq_abort_word #(.W(ABRT_W)) u_abrt (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_i  (src_in[TXA_BIT]),
      .src_i  (abrt_src_in),
      .clr_i  (clr_hit[TXA_BIT] | clr_all),
      .word_o (abrt_q)
   );

   irq_reg_port #(
      .NUM_SRC  (NUM_SRC),
      .LVL_MSK  (LVL_MSK),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .ABRT_W   (ABRT_W),
      .MASK_RST (MASK_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .rd_en     (rd_en),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .raw_i     (raw_stat),
      .abrt_i    (abrt_q),
      .mask_o    (mask_q),
      .clr_hit_o (clr_hit),
      .clr_all_o (clr_all),
      .rd_data_o (rd_data)
   );

   assign irq = |(raw_stat & mask_q);
endmodule

// File: rtl/irq_rdclr_ctrl_chk.sv
module irq_rdclr_ctrl_chk
   import irq_rdclr_pkg::*;
#(
   parameter int unsigned          NUM_SRC = 12,
   parameter logic [NUM_SRC-1:0]   LVL_MSK = 12'h014,
   parameter int unsigned          TXA_BIT = 6,
   parameter int unsigned          ADDR_W  = 8,
   parameter int unsigned          ABRT_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_in,
   input logic [ADDR_W-1:0]  addr,
   input logic               rd_en,
   input logic               wr_en,
   input logic [NUM_SRC-1:0] raw,
   input logic [NUM_SRC-1:0] mask,
   input logic [ABRT_W-1:0]  abrt,
   input logic               irq
);
   localparam logic [NUM_SRC-1:0] STICKY  = ~LVL_MSK;
   localparam int unsigned        TXA_OFF = clr_off(TXA_BIT, 32'(LVL_MSK));

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      if (!LVL_MSK[i]) begin : g_stk
         AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            src_in[i] |=> raw[i]);  // R8
      end
   end

   AST_IRQ_IS_MASKED_OR: assert property (@(posedge clk) disable iff (!rst_n)
      irq == |(raw & mask));  // R4

   AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == ADDR_W'(OFF_MASK)) |=> $stable(mask));  // R5

   AST_CLR_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(OFF_CLR_ALL) && (src_in & STICKY) == '0)
      |=> (raw & STICKY) == '0);  // R7

   AST_ABRT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && (addr == ADDR_W'(OFF_CLR_ALL) || addr == ADDR_W'(TXA_OFF)))
      |=> (abrt & $past(abrt)) == $past(abrt));  // R9
endmodule

bind irq_rdclr_ctrl irq_rdclr_ctrl_chk #(
   .NUM_SRC (NUM_SRC),
   .LVL_MSK (LVL_MSK),
   .TXA_BIT (TXA_BIT),
   .ADDR_W  (ADDR_W),
   .ABRT_W  (ABRT_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .src_in (src_in),
   .addr   (addr),
   .rd_en  (rd_en),
   .wr_en  (wr_en),
   .raw    (raw_stat),
   .mask   (mask_q),
   .abrt   (abrt_q),
   .irq    (irq)
);

// File: tb/irq_rdclr_ctrl_tb.sv
`timescale 1ns/1ps
module irq_rdclr_ctrl_tb;
   localparam logic [11:0] LVL = 12'h014;
   localparam logic [11:0] STK = 12'hFEB;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] src_in = '0;
   logic [15:0] abrt_src_in = '0;
   logic [7:0]  addr = '0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq;

   logic [11:0] lvl_hold = '0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_rdclr_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .abrt_src_in(abrt_src_in),
      .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .irq(irq)
   );

   function automatic logic [7:0] clr_addr(input int i);
      int slot;
      slot = 0;
      for (int k = 0; k < i; k++) if (!LVL[k]) slot++;
      return 8'(8'h44 + 4 * slot);
   endfunction

   task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic rdp(input logic [7:0] a, input logic [11:0] p,
                      input logic [15:0] ab, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1; src_in = lvl_hold | p; abrt_src_in = ab;
      @(negedge clk);
      rd_en = 1'b0; src_in = lvl_hold; abrt_src_in = '0;
      d = rd_data;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      rdp(a, 12'h0, 16'h0, d);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] v);
      @(negedge clk);
      addr = a; wr_en = 1'b1; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [11:0] p, input logic [15:0] ab);
      @(negedge clk);
      src_in = lvl_hold | p; abrt_src_in = ab;
      @(negedge clk);
      src_in = lvl_hold; abrt_src_in = '0;
   endtask

   task automatic set_lvl(input logic [11:0] v);
      @(negedge clk);
      lvl_hold = v & LVL; src_in = lvl_hold;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [11:0] m, rawp, mk;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(8'h34, d); chk(d, 32'h0, "R1 raw after reset");
      rd(8'h30, d); chk(d, 32'h254, "R5 mask reset value");
      rd(8'h80, d); chk(d, 32'h0, "R9 abort word after reset");
      chk({31'b0, irq}, 32'h0, "R4 irq after reset");

      // per-bit sweep
      for (int i = 0; i < 12; i++) begin
         if (LVL[i]) begin
            set_lvl(12'(1 << i));
            rd(8'h34, d); chk(d, 32'(1 << i), "R2 level bit follows high");
            set_lvl(12'h0);
            rd(8'h34, d); chk(d, 32'h0, "R2 level bit follows low");
         end else begin
            pulse(12'(1 << i), (i == 6) ? 16'h0001 : 16'h0);
            rd(8'h34, d); chk(d, 32'(1 << i), "R1 pulse sets sticky bit");
            rd(8'h34, d); chk(d, 32'(1 << i), "R1 sticky bit holds");
            rd(clr_addr(i), d); chk(d, 32'h1, "R6 clear read returns set bit");
            rd(8'h34, d); chk(d, 32'h0, "R6 clear read clears bit");
            rd(clr_addr(i), d); chk(d, 32'h0, "R6 clear read returns zero");
            if (i == 6) begin
               rd(8'h80, d); chk(d, 32'h0, "R9 abort clear empties word");
            end
         end
      end

      // level bits survive all clears
      set_lvl(LVL);
      rd(8'h40, d); chk(d, 32'h0, "R7 combined clear ignores level bits");
      rd(8'h34, d); chk(d, 32'(LVL), "R2 level bits not cleared by combined clear");
      set_lvl(12'h0);

      // clear one at a time from all set
      pulse(STK, 16'h0);
      m = STK;
      rd(8'h80, d);
      for (int i = 0; i < 12; i++) begin
         if (!LVL[i]) begin
            rd(clr_addr(i), d); chk(d, 32'h1, "R6 per-source clear return");
            m[i] = 1'b0;
            rd(8'h34, d); chk(d, 32'(m), "R6 only addressed bit cleared");
         end
      end
      rd(8'h40, d);

      // one-hot mask sweep with all raw set
      pulse(STK, 16'h0);
      set_lvl(LVL);
      for (int i = 0; i < 12; i++) begin
         wr(8'h30, 32'(1 << i));
         rd(8'h2C, d); chk(d, 32'(1 << i), "R3 masked one-hot");
         chk({31'b0, irq}, 32'h1, "R4 irq one-hot mask");
         rd(8'h30, d); chk(d, 32'(1 << i), "R5 mask readback");
      end
      wr(8'h30, 32'h0);
      rd(8'h2C, d); chk(d, 32'h0, "R3 masked with zero mask");
      chk({31'b0, irq}, 32'h0, "R4 irq with zero mask");

      // mixed raw and mask patterns
      for (int k = 0; k < 12; k++) begin
         rd(8'h40, d);
         set_lvl((k % 2 == 1) ? LVL : 12'h0);
         rawp = 12'((k * 32'h2C9 + 32'h135) & 32'(STK));
         mk   = 12'((k * 32'h5A3) ^ 32'h6B1);
         if (k == 5) mk = 12'h0;
         pulse(rawp, 16'h0);
         wr(8'h30, {20'h0, mk});
         rd(8'h34, d); chk(d, 32'(rawp | lvl_hold), "R1 raw pattern");
         rd(8'h2C, d); chk(d, 32'((rawp | lvl_hold) & mk), "R3 masked pattern");
         chk({31'b0, irq}, {31'b0, |((rawp | lvl_hold) & mk)}, "R4 irq pattern");
      end

      // combined clear
      rd(8'h40, d);
      pulse(STK, 16'h0);
      set_lvl(LVL);
      wr(8'h30, 32'hFFF);
      rd(8'h40, d); chk(d, 32'h1, "R7 combined clear returns any-set");
      rd(8'h34, d); chk(d, 32'(LVL), "R7 only level bits remain");
      rd(8'h30, d); chk(d, 32'hFFF, "R7 mask kept by combined clear");
      rd(8'h40, d); chk(d, 32'h0, "R7 second combined clear returns zero");
      set_lvl(12'h0);

      // same-cycle set and clear
      pulse(12'h200, 16'h0);
      rdp(clr_addr(9), 12'h200, 16'h0, d); chk(d, 32'h1, "R8 clear read returns bit");
      rd(8'h34, d); chk(d, 32'h200, "R8 pulse during own clear keeps bit");
      rdp(8'h40, 12'h008, 16'h0, d);
      rd(8'h34, d); chk(d, 32'h008, "R8 pulse during combined clear keeps bit");
      rd(8'h40, d);

      // abort word
      pulse(12'h040, 16'h0003);
      pulse(12'h040, 16'h0100);
      rd(8'h80, d); chk(d, 32'h0103, "R9 abort word accumulates");
      rd(8'h58, d);
      rd(8'h80, d); chk(d, 32'h0103, "R9 other clear leaves abort word");
      rd(8'h54, d); chk(d, 32'h1, "R9 abort bit clear return");
      rd(8'h80, d); chk(d, 32'h0, "R9 abort clear empties word");
      pulse(12'h040, 16'h0010);
      rdp(8'h54, 12'h040, 16'h0400, d);
      rd(8'h80, d); chk(d, 32'h0400, "R9 capture during clear keeps new value");
      rd(8'h40, d);
      rd(8'h80, d); chk(d, 32'h0, "R9 combined clear empties word");

      // ignored accesses
      pulse(12'h0A1, 16'h0);
      wr(8'h34, 32'h0);
      wr(clr_addr(0), 32'h0);
      wr(8'h40, 32'h0);
      rd(8'h34, d); chk(d, 32'h0A1, "R10 writes to non-mask offsets ignored");
      rd(8'h2C, d);
      rd(8'h30, d);
      rd(8'h34, d); chk(d, 32'h0A1, "R10 non-clear reads do not clear");
      wr(8'h2C, 32'h0);
      rd(8'h30, d); chk(d, 32'hFFF, "R10 write to masked status ignored");
      rd(8'h90, d); chk(d, 32'h0, "R11 unmapped offset reads zero");
      rd(8'h70, d); chk(d, 32'h0, "R11 unmapped offset reads zero");
      rd(8'h30, d); chk(d, 32'hFFF, "R11 read data after one edge");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule